// File: doc/BRIEF.md
# Predicated Contiguous Byte Store Sequencer

This block carries out a masked store of one vector register to a run of consecutive byte addresses. On a start request it captures the vector contents, a predicate with one bit per vector byte, a two-bit element-size code, a 64-bit base and a 64-bit index. It then visits the elements in ascending order and emits one single-byte write on a valid/ready write port for every element whose predicate bit is set. Each write carries only the low byte of its element. The address of element `e` is `base + index + e`. Inactive elements still use up their address slot.

Before any write goes out, the block checks two things. First, it rejects a request whose index register number is 31 as an undefined encoding. Second, when the base register number is 31 it treats the base as the stack pointer and checks that it is 16-byte aligned. The block ends every request with a single-cycle done pulse, and the two fault flags are valid in that same cycle.

There are two walk modes. In the data-independent timing mode the block spends one cycle on every element, active or not. In the normal mode it jumps straight from one active element to the next. In both modes the cycle count depends only on the predicate and on write-port back-pressure.

Top module: `pss_store_seq`

## Requirements
- R1: The element size in bits is 8 shifted left by `esz_i` (8, 16, 32 or 64). The number of elements is VL divided by that size.
- R2: Element `e` is active when predicate bit `e << esz_i` is 1. Only active elements produce a write, and each write carries bits `[e*esize +: 8]` of the vector.
- R3: The write address of element `e` is `base_i + index_i + e` modulo 2^64. Elements go out in ascending order, and the address advances past inactive elements.
- R4: While `wr_valid_o` is high and `wr_ready_i` is low, the valid, address and data stay unchanged until the next cycle.
- R5: If `idx_reg_i` equals 31, the request ends with `fault_undef_o` and `done_o` high in the cycle after start, with no write. This fault takes precedence over the alignment fault.
- R6: If `base_reg_i` equals 31, at least one element is active and `base_i[3:0]` is not zero, the request ends with `fault_align_o` and `done_o` one cycle after start, with no write.
- R7: With no active element, no write is issued and done follows one cycle after start. A misaligned stack-pointer base then raises `fault_align_o` only when `sp_chk_empty_i` is 1.
- R8: `done_o` is a single-cycle pulse in the cycle after the last element is handled. The fault flags are high only together with `done_o`.
- R9: With `dit_i` = 1 and at least one active element, the number of rising edges from the start edge up to and including the edge that raises done is the element count plus 1 plus the number of stalled write cycles, whatever the vector data.
- R10: With `dit_i` = 0 and at least one active element, that edge count is the active-element count plus 1 plus the number of stalled write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| vec_i | input | VL_BITS | Vector data to store |
| pred_i | input | VL_BITS/8 | Predicate, one bit per vector byte |
| esz_i | input | 2 | Element-size code |
| base_i | input | 64 | Base address (stack pointer value when base_reg_i is 31) |
| index_i | input | 64 | Byte index added to the base |
| idx_reg_i | input | 5 | Index register number, 31 is illegal |
| base_reg_i | input | 5 | Base register number, 31 selects the stack pointer |
| sp_chk_empty_i | input | 1 | Check stack-pointer alignment even with no active element |
| dit_i | input | 1 | Data-independent timing walk |
| wr_valid_o | output | 1 | Byte write request valid |
| wr_ready_i | input | 1 | Write port accepts the request |
| wr_addr_o | output | 64 | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| done_o | output | 1 | End-of-request pulse |
| fault_undef_o | output | 1 | Undefined-encoding fault, valid with done |
| fault_align_o | output | 1 | Stack-pointer alignment fault, valid with done |

## Verification
A request is counted from the rising edge that samples `start_i`. A fault, or an empty predicate, shows `done_o` after that one edge. A request that writes shows its first write after the same edge. After that, each further edge hands over one element, or holds it if the port stalls. Done appears one edge after the last element, so the total is the element count or active count plus one plus stalls. The bench drives inputs and `wr_ready_i` on the falling edge and samples every output there. It counts edges and stalls itself and compares that count against the formula for the selected mode. Each accepted write is compared with the next entry of an expected list computed from the predicate, the size code and the base and index inputs.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_FIN  = 2'd2
    } pss_state_e;

    localparam logic [4:0] PSS_ZERO_REG  = 5'd31;
    localparam int         PSS_SP_ALIGN  = 4;

endpackage

// File: rtl/pss_elem_mask.sv
module pss_elem_mask #(
    parameter int PL = 32
) (
    input  logic [PL-1:0] pred_i,
    input  logic [1:0]    esz_i,
    output logic [PL-1:0] emask_o
);

    logic [PL-1:0] m_b;
    logic [PL-1:0] m_h;
    logic [PL-1:0] m_w;
    logic [PL-1:0] m_d;

    for (genvar e = 0; e < PL; e++) begin : g_el
        assign m_b[e] = pred_i[e];
        if (e * 2 < PL) begin : g_h
            assign m_h[e] = pred_i[e*2];
        end else begin : g_hz
            assign m_h[e] = 1'b0;
        end
        if (e * 4 < PL) begin : g_w
            assign m_w[e] = pred_i[e*4];
        end else begin : g_wz
            assign m_w[e] = 1'b0;
        end
        if (e * 8 < PL) begin : g_d
            assign m_d[e] = pred_i[e*8];
        end else begin : g_dz
            assign m_d[e] = 1'b0;
        end
    end

    always_comb begin
        unique case (esz_i)
            2'd0:    emask_o = m_b;
            2'd1:    emask_o = m_h;
            2'd2:    emask_o = m_w;
            default: emask_o = m_d;
        endcase
    end

endmodule

// File: rtl/pss_next_active.sv
module pss_next_active #(
    parameter int PL = 32,
    parameter int CW = 6
) (
    input  logic [PL-1:0] mask_i,
    input  logic [CW-1:0] from_i,
    output logic          found_o,
    output logic [CW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int e = PL - 1; e >= 0; e--) begin
            if (mask_i[e] && (CW'(e) >= from_i)) begin
                found_o = 1'b1;
                idx_o   = CW'(e);
            end
        end
    end

endmodule

// File: rtl/pss_elem_pick.sv
module pss_elem_pick #(
    parameter int VL_BITS = 256,
    parameter int PL      = VL_BITS / 8
) (
    input  logic [VL_BITS-1:0]     vec_i,
    input  logic [$clog2(PL)-1:0]  cur_i,
    input  logic [1:0]             esz_i,
    output logic [7:0]             byte_o
);

    localparam int BW = $clog2(PL);

    logic [BW-1:0] byte_idx;

    assign byte_idx = cur_i << esz_i;
    assign byte_o   = vec_i[{byte_idx, 3'b000} +: 8];

endmodule

// File: rtl/pss_fault_gate.sv
module pss_fault_gate
    import pss_pkg::*;
(
    input  logic [4:0]              idx_reg_i,
    input  logic [4:0]              base_reg_i,
    input  logic [PSS_SP_ALIGN-1:0] base_lo_i,
    input  logic                    any_active_i,
    input  logic                    chk_empty_i,
    output logic                    undef_o,
    output logic                    align_o
);

    logic sp_used;
    logic chk_wanted;

    assign undef_o    = (idx_reg_i == PSS_ZERO_REG);
    assign sp_used    = (base_reg_i == PSS_ZERO_REG);
    assign chk_wanted = any_active_i || chk_empty_i;
    assign align_o    = !undef_o && sp_used && chk_wanted && (base_lo_i != '0);

endmodule

// File: rtl/pss_store_seq.sv
module pss_store_seq
    import pss_pkg::*;
#(
    parameter int VL_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [VL_BITS-1:0]   vec_i,
    input  logic [VL_BITS/8-1:0] pred_i,
    input  logic [1:0]           esz_i,
    input  logic [63:0]          base_i,
    input  logic [63:0]          index_i,
    input  logic [4:0]           idx_reg_i,
    input  logic [4:0]           base_reg_i,
    input  logic                 sp_chk_empty_i,
    input  logic                 dit_i,
    output logic                 wr_valid_o,
    input  logic                 wr_ready_i,
    output logic [63:0]          wr_addr_o,
    output logic [7:0]           wr_data_o,
    output logic                 done_o,
    output logic                 fault_undef_o,
    output logic                 fault_align_o
);

    localparam int PL = VL_BITS / 8;
    localparam int BW = $clog2(PL);
    localparam int CW = BW + 1;

    typedef struct packed {
        pss_state_e        st;
        logic [CW-1:0]     cur;
        logic [CW-1:0]     last;
        logic [63:0]       addr0;
        logic [VL_BITS-1:0] vec;
        logic [PL-1:0]     emask;
        logic [1:0]        esz;
        logic              dit;
        logic              f_undef;
        logic              f_align;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic [PL-1:0] emask_new;
    logic          any_new;
    logic          undef_new;
    logic          align_new;
    logic [PL-1:0] srch_mask;
    logic [CW-1:0] srch_from;
    logic          nxt_found;
    logic [CW-1:0] nxt_idx;
    logic          cur_act;
    logic          handled;
    logic [7:0]    pick_byte;

    pss_elem_mask #(.PL(PL)) u_mask (
        .pred_i  (pred_i),
        .esz_i   (esz_i),
        .emask_o (emask_new)
    );

    assign any_new = |emask_new;

    pss_fault_gate u_fault (
        .idx_reg_i    (idx_reg_i),
        .base_reg_i   (base_reg_i),
        .base_lo_i    (base_i[PSS_SP_ALIGN-1:0]),
        .any_active_i (any_new),
        .chk_empty_i  (sp_chk_empty_i),
        .undef_o      (undef_new),
        .align_o      (align_new)
    );

    assign srch_mask = (seq_q.st == ST_IDLE) ? emask_new : seq_q.emask;
    assign srch_from = (seq_q.st == ST_IDLE) ? '0 : seq_q.cur + 1'b1;

    pss_next_active #(.PL(PL), .CW(CW)) u_next (
        .mask_i  (srch_mask),
        .from_i  (srch_from),
        .found_o (nxt_found),
        .idx_o   (nxt_idx)
    );

    pss_elem_pick #(.VL_BITS(VL_BITS), .PL(PL)) u_pick (
        .vec_i  (seq_q.vec),
        .cur_i  (seq_q.cur[BW-1:0]),
        .esz_i  (seq_q.esz),
        .byte_o (pick_byte)
    );

    assign cur_act = seq_q.emask[seq_q.cur[BW-1:0]];
    assign handled = !cur_act || wr_ready_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.vec     = vec_i;
                    seq_d.emask   = emask_new;
                    seq_d.esz     = esz_i;
                    seq_d.dit     = dit_i;
                    seq_d.addr0   = base_i + index_i;
                    seq_d.last    = CW'(PL - 1) >> esz_i;
                    seq_d.f_undef = undef_new;
                    seq_d.f_align = align_new;
                    if (undef_new || align_new || !any_new) begin
                        seq_d.st  = ST_FIN;
                        seq_d.cur = '0;
                    end else begin
                        seq_d.st  = ST_WALK;
                        seq_d.cur = dit_i ? '0 : nxt_idx;
                    end
                end
            end
            ST_WALK: begin
                if (handled) begin
                    if (seq_q.dit) begin
                        if (seq_q.cur == seq_q.last) begin
                            seq_d.st = ST_FIN;
                        end else begin
                            seq_d.cur = seq_q.cur + 1'b1;
                        end
                    end else if (nxt_found) begin
                        seq_d.cur = nxt_idx;
                    end else begin
                        seq_d.st = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                seq_d.st      = ST_IDLE;
                seq_d.f_undef = 1'b0;
                seq_d.f_align = 1'b0;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid_o    = (seq_q.st == ST_WALK) && cur_act;
    assign wr_addr_o     = seq_q.addr0 + 64'(seq_q.cur);
    assign wr_data_o     = pick_byte;
    assign done_o        = (seq_q.st == ST_FIN);
    assign fault_undef_o = done_o && seq_q.f_undef;
    assign fault_align_o = done_o && seq_q.f_align;

endmodule

// File: rtl/pss_store_seq_chk.sv
module pss_store_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [4:0]  idx_reg_i,
    input logic        wr_valid_o,
    input logic        wr_ready_i,
    input logic [63:0] wr_addr_o,
    input logic [7:0]  wr_data_o,
    input logic        done_o,
    input logic        fault_undef_o,
    input logic        fault_align_o
);

    logic busy_q;
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            if (done_o) begin
                busy_q <= 1'b0;
            end else if (start_i) begin
                busy_q <= 1'b1;
            end
            if (done_o) begin
                wrote_q <= 1'b0;
            end else if (wr_valid_o && wr_ready_i) begin
                wrote_q <= 1'b1;
            end
        end
    end

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R4

    AST_UNDEF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_q && (idx_reg_i == 5'd31) |=> done_o && fault_undef_o); // R5

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        fault_undef_o |-> !fault_align_o); // R5

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_undef_o || fault_align_o) |-> !wrote_q); // R6

    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_undef_o || fault_align_o) |-> done_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !wr_valid_o); // R2

endmodule

bind pss_store_seq pss_store_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .idx_reg_i     (idx_reg_i),
    .wr_valid_o    (wr_valid_o),
    .wr_ready_i    (wr_ready_i),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .done_o        (done_o),
    .fault_undef_o (fault_undef_o),
    .fault_align_o (fault_align_o)
);

// File: tb/pss_store_seq_bench.sv
module pss_store_seq_bench;

    localparam int VL = 256;
    localparam int PL = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [VL-1:0] vec_i = '0;
    logic [PL-1:0] pred_i = '0;
    logic [1:0]    esz_i = '0;
    logic [63:0]   base_i = '0;
    logic [63:0]   index_i = '0;
    logic [4:0]    idx_reg_i = '0;
    logic [4:0]    base_reg_i = '0;
    logic          sp_chk_empty_i = 1'b0;
    logic          dit_i = 1'b0;
    logic          wr_valid_o;
    logic          wr_ready_i = 1'b0;
    logic [63:0]   wr_addr_o;
    logic [7:0]    wr_data_o;
    logic          done_o;
    logic          fault_undef_o;
    logic          fault_align_o;

    int checks = 0;
    int errors = 0;
    int last_lat = 0;

    always #5 clk = ~clk;

    pss_store_seq #(.VL_BITS(VL)) u_pss_store_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .vec_i          (vec_i),
        .pred_i         (pred_i),
        .esz_i          (esz_i),
        .base_i         (base_i),
        .index_i        (index_i),
        .idx_reg_i      (idx_reg_i),
        .base_reg_i     (base_reg_i),
        .sp_chk_empty_i (sp_chk_empty_i),
        .dit_i          (dit_i),
        .wr_valid_o     (wr_valid_o),
        .wr_ready_i     (wr_ready_i),
        .wr_addr_o      (wr_addr_o),
        .wr_data_o      (wr_data_o),
        .done_o         (done_o),
        .fault_undef_o  (fault_undef_o),
        .fault_align_o  (fault_align_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int elem_count(input logic [1:0] s);
        return PL >> s;
    endfunction

    function automatic bit elem_active(input logic [PL-1:0] p, input logic [1:0] s, input int e);
        return p[e << s];
    endfunction

    task automatic run_op(input logic [VL-1:0] v, input logic [PL-1:0] p, input logic [1:0] s,
                          input logic [63:0] b, input logic [63:0] ix,
                          input logic [4:0] ir, input logic [4:0] br,
                          input bit ce, input bit dm, input int rdy_pct);
        logic [63:0] exp_addr [PL];
        logic [7:0]  exp_byte [PL];
        int n, nexp, nw, lat, stalls, exp_lat;
        bit anyact, eu, ea, got_done, prev_stall;
        logic [63:0] p_addr;
        logic [7:0]  p_byte;
        n = elem_count(s);
        nexp = 0;
        anyact = 1'b0;
        for (int e = 0; e < n; e++) begin
            if (elem_active(p, s, e)) begin
                anyact = 1'b1;
                exp_addr[nexp] = b + ix + 64'(e);
                exp_byte[nexp] = v[e * (8 << s) +: 8];
                nexp++;
            end
        end
        eu = (ir == 5'd31);
        ea = !eu && (br == 5'd31) && (anyact || ce) && (b[3:0] != 4'h0);
        if (eu || ea) nexp = 0;
        if (eu || ea || !anyact) exp_lat = 1;
        else if (dm) exp_lat = n + 1;
        else exp_lat = nexp + 1;

        @(negedge clk);
        vec_i = v; pred_i = p; esz_i = s; base_i = b; index_i = ix;
        idx_reg_i = ir; base_reg_i = br; sp_chk_empty_i = ce; dit_i = dm;
        start_i = 1'b1;
        lat = 0; nw = 0; stalls = 0; got_done = 1'b0; prev_stall = 1'b0;
        p_addr = '0; p_byte = '0;
        while (!got_done && lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin
                got_done = 1'b1;
            end else begin
                if (prev_stall) begin
                    chk(wr_valid_o && wr_addr_o == p_addr && wr_data_o == p_byte, "R4",
                        "held address", wr_addr_o, p_addr);
                end
                wr_ready_i = (int'($urandom % 100) < rdy_pct);
                if (wr_valid_o) begin
                    if (wr_ready_i) begin
                        if (nw < nexp) begin
                            chk(wr_addr_o == exp_addr[nw], "R3", "write address", wr_addr_o, exp_addr[nw]);
                            chk(wr_data_o == exp_byte[nw], "R2", "write byte", 64'(wr_data_o), 64'(exp_byte[nw]));
                        end
                        nw++;
                        prev_stall = 1'b0;
                    end else begin
                        stalls++;
                        prev_stall = 1'b1;
                        p_addr = wr_addr_o;
                        p_byte = wr_data_o;
                    end
                end else begin
                    prev_stall = 1'b0;
                end
            end
        end
        chk(got_done, "R8", "done seen", 64'(got_done), 64'd1);
        chk(fault_undef_o == eu, "R5", "undefined fault", 64'(fault_undef_o), 64'(eu));
        chk(fault_align_o == ea, anyact ? "R6" : "R7", "alignment fault", 64'(fault_align_o), 64'(ea));
        chk(nw == nexp, "R2", "write count", 64'(nw), 64'(nexp));
        chk(lat == exp_lat + stalls, dm ? "R9" : "R10", "latency", 64'(lat), 64'(exp_lat + stalls));
        last_lat = lat - stalls;
        wr_ready_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!done_o && !fault_undef_o && !fault_align_o, "R8", "done pulse width", 64'(done_o), 64'd0);
    endtask

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] r;
        for (int i = 0; i < VL / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int l_a;
        logic [VL-1:0] va;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done_o && !wr_valid_o && !fault_undef_o && !fault_align_o, "R8", "reset outputs",
            {60'd0, done_o, wr_valid_o, fault_undef_o, fault_align_o}, 64'd0);
        rst_n = 1'b1;

        // R1: every size, full predicate, both modes
        for (int s = 0; s < 4; s++) begin
            run_op(rnd_vec(), '1, 2'(s), 64'h1000, 64'h20, 5'd3, 5'd4, 1'b0, 1'b1, 100);
            run_op(rnd_vec(), '1, 2'(s), 64'h2000, 64'h7, 5'd3, 5'd4, 1'b0, 1'b0, 60);
        end
        // R2: only upper bits of wide elements set -> nothing active
        run_op(rnd_vec(), 32'hAAAA_AAAA, 2'd1, 64'h40, 64'h0, 5'd1, 5'd2, 1'b0, 1'b1, 100);
        // R2 R3: sparse predicate, inactive slots still advance
        run_op(rnd_vec(), 32'h8000_0101, 2'd0, 64'h500, 64'h3, 5'd1, 5'd2, 1'b0, 1'b0, 100);
        run_op(rnd_vec(), 32'h0100_0010, 2'd2, 64'h500, 64'h3, 5'd1, 5'd2, 1'b0, 1'b1, 50);
        // R3: wrap modulo 2^64
        run_op(rnd_vec(), '1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 5'd1, 5'd31, 1'b0, 1'b1, 100);
        // R5: illegal index register, also with misaligned stack pointer
        run_op(rnd_vec(), '1, 2'd0, 64'h100, 64'h0, 5'd31, 5'd2, 1'b0, 1'b0, 100);
        run_op(rnd_vec(), '1, 2'd0, 64'h103, 64'h0, 5'd31, 5'd31, 1'b1, 1'b1, 100);
        // R6: stack pointer aligned and misaligned
        run_op(rnd_vec(), 32'h0000_F00F, 2'd0, 64'h7770, 64'h1, 5'd1, 5'd31, 1'b0, 1'b0, 100);
        run_op(rnd_vec(), 32'h0000_F00F, 2'd0, 64'h7778, 64'h1, 5'd1, 5'd31, 1'b0, 1'b0, 100);
        // R7: empty predicate with misaligned stack pointer, check off and on
        run_op(rnd_vec(), '0, 2'd0, 64'h7774, 64'h0, 5'd1, 5'd31, 1'b0, 1'b1, 100);
        run_op(rnd_vec(), '0, 2'd0, 64'h7774, 64'h0, 5'd1, 5'd31, 1'b1, 1'b1, 100);
        // R9: same predicate, different data -> same latency
        va = rnd_vec();
        run_op(va, 32'h1234_5678, 2'd0, 64'h900, 64'h0, 5'd1, 5'd2, 1'b0, 1'b1, 100);
        l_a = last_lat;
        run_op(~va, 32'h1234_5678, 2'd0, 64'h900, 64'h0, 5'd1, 5'd2, 1'b0, 1'b1, 100);
        chk(last_lat == l_a, "R9", "data-independent latency", 64'(last_lat), 64'(l_a));

        // random mix
        for (int k = 0; k < 250; k++) begin
            logic [4:0] ir;
            logic [4:0] br;
            logic [63:0] b;
            logic [PL-1:0] p;
            ir = (($urandom % 16) == 0) ? 5'd31 : 5'(($urandom % 31));
            br = (($urandom % 4) == 0) ? 5'd31 : 5'(($urandom % 31));
            b  = {$urandom, $urandom};
            if ($urandom % 2 == 0) b[3:0] = 4'h0;
            case ($urandom % 4)
                0: p = '0;
                1: p = '1;
                default: p = $urandom;
            endcase
            run_op(rnd_vec(), p, 2'($urandom % 4), b, {$urandom, $urandom}, ir, br,
                   1'($urandom % 2), 1'($urandom % 2), 30 + int'($urandom % 71));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule